// File: doc/BRIEF.md
# Hit-Ratio-Driven Region Granularity Controller

This block sits beside the mapping cache of a wear-levelling memory controller. It watches the result of every cache lookup and counts lookups and hits over a fixed window. When the window closes, it compares the hit ratio against two thresholds. A high hit ratio means the cache can afford finer regions, so the block asks an external adjust engine to split regions. A low hit ratio means the cache is thrashing, so it asks for a merge, which makes regions coarser. A ratio in the band between the two thresholds leaves the regions as they are.

The request goes out over a request/acknowledge pair. A split finishes in a few cycles. A merge moves data physically, so its acknowledge may take much longer. After an acknowledged adjustment the block lets a settling window of lookups pass before it observes again. It keeps a granularity level between a configured floor and ceiling, and it drops any request that would push the level past either bound.

The thresholds are tested with integer arithmetic on the hit count, so the block needs no divider. Data movement, table updates and the cache itself lie outside the block.

Top module: `granularity_ctrl`

## Requirements
- R1: While observing, the window closes on the WINDOW_LEN-th cycle with `lk_valid` high. Cycles with `lk_valid` low are not counted, and their `lk_hit` value is ignored. The verdict for a closed window appears on `adj_req` in the next cycle.
- R2: When a window closes with hits*100 >= SPLIT_PCT*WINDOW_LEN (default 95 %), `adj_req` rises with `adj_split` = 1 (split).
- R3: When a window closes with hits*100 <= MERGE_PCT*WINDOW_LEN (default 90 %), `adj_req` rises with `adj_split` = 0 (merge).
- R4: A window whose ratio lies strictly between the two thresholds raises no request. The next window starts with the next accepted lookup.
- R5: `adj_req` and `adj_split` stay constant until the cycle in which `adj_ack` is sampled high. `adj_req` is low in the cycle after that.
- R6: Lookups presented while a request is pending do not count toward any window and do not advance the settling count.
- R7: After the acknowledge, the next SETTLE_LEN accepted lookups are ignored for statistics. The lookup after them is the first lookup of a new window.
- R8: `gran_level` changes only on an acknowledged request. It drops by one for a split and rises by one for a merge, and it always stays within [LVL_MIN, LVL_MAX].
- R9: A split verdict at LVL_MIN or a merge verdict at LVL_MAX raises no request. The block starts a new window at once.
- R10: A synchronous reset (`rst` high) lowers `adj_req`, sets `gran_level` to LVL_INIT, clears both counts and returns the block to observing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A lookup result is present this cycle |
| lk_hit | input | 1 | The lookup hit the mapping cache (used only when `lk_valid` is high) |
| adj_ack | input | 1 | The adjust engine has completed the pending request |
| adj_req | output | 1 | Adjustment request, held until acknowledged |
| adj_split | output | 1 | Request direction: 1 = split (finer), 0 = merge (coarser) |
| gran_level | output | LEVEL_W | Current granularity level |

## Verification
The hardest case to provoke is a lookup arriving while a request is pending or during the settling window. Such a lookup changes nothing visible at once, and its effect would only show up as a window that closes early or late some time afterwards. To expose this, the stimulus keeps driving misses for every cycle of each handshake and drives hits throughout each settling window. The responder stretches the merge acknowledge to eight cycles. Every following window is then checked to close on exactly its last lookup. The level-limit suppression needs a run of consecutive merges or splits to reach a bound first, so the sequence walks the level down to the floor and up to the ceiling before presenting verdicts there.

// File: rtl/gran_pkg.sv
package gran_pkg;

   typedef enum logic [1:0] {
      GC_OBSERVE = 2'd0,
      GC_REQUEST = 2'd1,
      GC_SETTLE  = 2'd2
   } gc_state_e;

   typedef enum logic {
      ADJ_MERGE = 1'b0,
      ADJ_SPLIT = 1'b1
   } adj_dir_e;

endpackage

// File: rtl/gc_window_stats.sv
module gc_window_stats #(
   parameter int unsigned WINDOW_LEN = 4194304,
   parameter int unsigned CNT_W      = $clog2(WINDOW_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             obs_en,
   input  logic             lk_valid,
   input  logic             lk_hit,
   output logic             win_end,
   output logic [CNT_W-1:0] hits_total
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW_LEN - 1);

   generate
      if (WINDOW_LEN < 1) begin : g_bad_len
         $error("gc_window_stats: WINDOW_LEN must be at least 1");
      end
      if (CNT_W < $clog2(WINDOW_LEN + 1)) begin : g_bad_w
         $error("gc_window_stats: CNT_W too narrow for WINDOW_LEN");
      end
   endgenerate

   logic [CNT_W-1:0] seen_q;
   logic [CNT_W-1:0] hit_q;
   logic             take;

   assign take       = obs_en && lk_valid;
   assign win_end    = take && (seen_q == LAST_IDX);
   assign hits_total = hit_q + CNT_W'(lk_hit);

   always_ff @(posedge clk) begin
      if (rst || win_end) begin
         seen_q <= '0;
         hit_q  <= '0;
      end else if (take) begin
         seen_q <= seen_q + 1'b1;
         hit_q  <= hit_q + CNT_W'(lk_hit);
      end
   end

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q <= LAST_IDX);

   // R1
   hits_within_seen_chk: assert property (@(posedge clk) disable iff (rst)
      hit_q <= seen_q);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !obs_en |=> $stable(seen_q));

endmodule

// File: rtl/gc_ratio_judge.sv
module gc_ratio_judge #(
   parameter int unsigned WINDOW_LEN  = 4194304,
   parameter int unsigned SPLIT_PCT   = 95,
   parameter int unsigned MERGE_PCT   = 90,
   parameter int unsigned CNT_W       = $clog2(WINDOW_LEN + 1),
   parameter int unsigned JUDGE_STYLE = 0
) (
   input  logic [CNT_W-1:0] hits,
   output logic             want_split,
   output logic             want_merge
);

   generate
      if (JUDGE_STYLE == 0) begin : g_const
         // hit-count bounds folded at elaboration: plain comparators remain
         localparam longint unsigned SPLIT_FLOOR =
            (64'(SPLIT_PCT) * 64'(WINDOW_LEN) + 64'd99) / 64'd100;
         localparam longint unsigned MERGE_CEIL =
            (64'(MERGE_PCT) * 64'(WINDOW_LEN)) / 64'd100;
         assign want_split = 64'(hits) >= SPLIT_FLOOR;
         assign want_merge = 64'(hits) <= MERGE_CEIL;
      end else if (JUDGE_STYLE == 1) begin : g_scaled
         // hits scaled by 100 and compared with pct*window products
         logic [63:0] scaled;
         assign scaled     = 64'(hits) * 64'd100;
         assign want_split = scaled >= 64'(SPLIT_PCT) * 64'(WINDOW_LEN);
         assign want_merge = scaled <= 64'(MERGE_PCT) * 64'(WINDOW_LEN);
      end else begin : g_bad_style
         $error("gc_ratio_judge: JUDGE_STYLE must be 0 or 1");
         assign want_split = 1'b0;
         assign want_merge = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/gc_settle_timer.sv
module gc_settle_timer #(
   parameter int unsigned SETTLE_LEN = 4194304,
   parameter int unsigned ST_W       = $clog2(SETTLE_LEN + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic settle_en,
   input  logic lk_valid,
   output logic settle_done
);

   localparam logic [ST_W-1:0] LAST_IDX = ST_W'(SETTLE_LEN - 1);

   generate
      if (SETTLE_LEN < 1) begin : g_bad_len
         $error("gc_settle_timer: SETTLE_LEN must be at least 1");
      end
   endgenerate

   logic [ST_W-1:0] cnt_q;

   assign settle_done = settle_en && lk_valid && (cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst || settle_done || !settle_en) begin
         cnt_q <= '0;
      end else if (lk_valid) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_IDX);

endmodule

// File: rtl/gc_level_track.sv
module gc_level_track #(
   parameter int unsigned LEVEL_W  = 4,
   parameter int unsigned LVL_MIN  = 0,
   parameter int unsigned LVL_MAX  = 6,
   parameter int unsigned LVL_INIT = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_en,
   input  logic               step_split,
   output logic [LEVEL_W-1:0] level,
   output logic               at_min,
   output logic               at_max
);

   localparam logic [LEVEL_W-1:0] MIN_V  = LEVEL_W'(LVL_MIN);
   localparam logic [LEVEL_W-1:0] MAX_V  = LEVEL_W'(LVL_MAX);
   localparam logic [LEVEL_W-1:0] INIT_V = LEVEL_W'(LVL_INIT);

   generate
      if (LVL_MIN > LVL_MAX || LVL_INIT < LVL_MIN || LVL_INIT > LVL_MAX) begin : g_bad_order
         $error("gc_level_track: need LVL_MIN <= LVL_INIT <= LVL_MAX");
      end
      if (LVL_MAX >= (1 << LEVEL_W)) begin : g_bad_w
         $error("gc_level_track: LEVEL_W too narrow for LVL_MAX");
      end
   endgenerate

   logic [LEVEL_W-1:0] level_q;

   assign level  = level_q;
   assign at_min = (level_q == MIN_V);
   assign at_max = (level_q == MAX_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= INIT_V;
      end else if (step_en) begin
         if (step_split && !at_min) begin
            level_q <= level_q - 1'b1;
         end else if (!step_split && !at_max) begin
            level_q <= level_q + 1'b1;
         end
      end
   end

   // R8
   lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
      level_q >= MIN_V && level_q <= MAX_V);

   // R8
   lvl_step_chk: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(level_q));

endmodule

// File: rtl/granularity_ctrl.sv
module granularity_ctrl
   import gran_pkg::*;
#(
   parameter int unsigned WINDOW_LEN  = 4194304,
   parameter int unsigned SETTLE_LEN  = 4194304,
   parameter int unsigned SPLIT_PCT   = 95,
   parameter int unsigned MERGE_PCT   = 90,
   parameter int unsigned LEVEL_W     = 4,
   parameter int unsigned LVL_MIN     = 0,
   parameter int unsigned LVL_MAX     = 6,
   parameter int unsigned LVL_INIT    = 3,
   parameter int unsigned JUDGE_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               lk_valid,
   input  logic               lk_hit,
   input  logic               adj_ack,
   output logic               adj_req,
   output logic               adj_split,
   output logic [LEVEL_W-1:0] gran_level
);

   localparam int unsigned CNT_W = $clog2(WINDOW_LEN + 1);
   localparam int unsigned ST_W  = $clog2(SETTLE_LEN + 1);

   generate
      if (SPLIT_PCT > 100 || MERGE_PCT >= SPLIT_PCT) begin : g_bad_pct
         $error("granularity_ctrl: need MERGE_PCT < SPLIT_PCT <= 100");
      end
   endgenerate

   gc_state_e        st_q, st_d;
   adj_dir_e         dir_q, dir_d;
   logic             win_end;
   logic [CNT_W-1:0] hits_total;
   logic             want_split, want_merge;
   logic             settle_done;
   logic             at_min, at_max;

   gc_window_stats #(
      .WINDOW_LEN (WINDOW_LEN),
      .CNT_W      (CNT_W)
   ) u_stats (
      .clk        (clk),
      .rst        (rst),
      .obs_en     (st_q == GC_OBSERVE),
      .lk_valid   (lk_valid),
      .lk_hit     (lk_hit),
      .win_end    (win_end),
      .hits_total (hits_total)
   );

   gc_ratio_judge #(
      .WINDOW_LEN  (WINDOW_LEN),
      .SPLIT_PCT   (SPLIT_PCT),
      .MERGE_PCT   (MERGE_PCT),
      .CNT_W       (CNT_W),
      .JUDGE_STYLE (JUDGE_STYLE)
   ) u_judge (
      .hits       (hits_total),
      .want_split (want_split),
      .want_merge (want_merge)
   );

   gc_settle_timer #(
      .SETTLE_LEN (SETTLE_LEN),
      .ST_W       (ST_W)
   ) u_settle (
      .clk         (clk),
      .rst         (rst),
      .settle_en   (st_q == GC_SETTLE),
      .lk_valid    (lk_valid),
      .settle_done (settle_done)
   );

   gc_level_track #(
      .LEVEL_W  (LEVEL_W),
      .LVL_MIN  (LVL_MIN),
      .LVL_MAX  (LVL_MAX),
      .LVL_INIT (LVL_INIT)
   ) u_level (
      .clk        (clk),
      .rst        (rst),
      .step_en    (adj_req && adj_ack),
      .step_split (adj_split),
      .level      (gran_level),
      .at_min     (at_min),
      .at_max     (at_max)
   );

   always_comb begin
      st_d  = st_q;
      dir_d = dir_q;
      unique case (st_q)
         GC_OBSERVE: begin
            if (win_end) begin
               if (want_split && !at_min) begin
                  st_d  = GC_REQUEST;
                  dir_d = ADJ_SPLIT;
               end else if (want_merge && !at_max) begin
                  st_d  = GC_REQUEST;
                  dir_d = ADJ_MERGE;
               end
            end
         end
         GC_REQUEST: begin
            if (adj_ack) st_d = GC_SETTLE;
         end
         GC_SETTLE: begin
            if (settle_done) st_d = GC_OBSERVE;
         end
         default: st_d = GC_OBSERVE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= GC_OBSERVE;
         dir_q <= ADJ_MERGE;
      end else begin
         st_q  <= st_d;
         dir_q <= dir_d;
      end
   end

   assign adj_req   = (st_q == GC_REQUEST);
   assign adj_split = (dir_q == ADJ_SPLIT);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      adj_req && !adj_ack |=> adj_req && $stable(adj_split));

   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (rst)
      adj_req && adj_ack |=> !adj_req);

   // R9
   no_split_at_min_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(adj_req) && adj_split |-> !at_min);

   // R9
   no_merge_at_max_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(adj_req) && !adj_split |-> !at_max);

   // R10
   rst_state_chk: assert property (@(posedge clk)
      rst |=> !adj_req && gran_level == LEVEL_W'(LVL_INIT));

endmodule

// File: tb/tb_granularity_ctrl.sv
`timescale 1ns/1ps
module tb_granularity_ctrl;

   localparam int unsigned WIN    = 40;
   localparam int unsigned SETL   = 6;
   localparam int unsigned LW     = 3;
   localparam int unsigned LMIN   = 0;
   localparam int unsigned LMAX   = 3;
   localparam int unsigned LINIT  = 1;

   logic          clk = 1'b0;
   logic          rst;
   logic          lk_valid, lk_hit, adj_ack;
   logic          adj_req, adj_split;
   logic [LW-1:0] gran_level;

   int total = 0;
   int bad   = 0;
   int exp_lvl;
   bit finished = 0;

   typedef struct {bit split; int lvl;} exp_t;
   exp_t q[$];

   always #4 clk = ~clk;   // 125 MHz

   granularity_ctrl #(
      .WINDOW_LEN (WIN),
      .SETTLE_LEN (SETL),
      .SPLIT_PCT  (95),
      .MERGE_PCT  (90),
      .LEVEL_W    (LW),
      .LVL_MIN    (LMIN),
      .LVL_MAX    (LMAX),
      .LVL_INIT   (LINIT),
      .JUDGE_STYLE(0)
   ) dut (
      .clk        (clk),
      .rst        (rst),
      .lk_valid   (lk_valid),
      .lk_hit     (lk_hit),
      .adj_ack    (adj_ack),
      .adj_req    (adj_req),
      .adj_split  (adj_split),
      .gran_level (gran_level)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic lookup(input bit v, input bit h);
      lk_valid = v;
      lk_hit   = h;
      @(negedge clk);
   endtask

   // responder: split acked at once, merge after 8 request cycles
   initial begin
      adj_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (adj_req && !adj_ack) begin
            repeat (adj_split ? 0 : 7) @(negedge clk);
            adj_ack = 1'b1;
            @(negedge clk);
            adj_ack = 1'b0;
         end
      end
   end

   // monitor: every new request is compared with the scoreboard head
   bit req_prev = 1'b0;
   always @(negedge clk) begin
      if (adj_req && !req_prev) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4/R9 unexpected request", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(adj_split == e.split, e.split ? "R2 direction" : "R3 direction",
                int'(adj_split), int'(e.split));
            chk(gran_level == LW'(e.lvl), "R8 level before ack", int'(gran_level), e.lvl);
         end
      end
      req_prev = adj_req;
   end

   // kind: 0 = no request, 1 = split, 2 = merge
   task automatic run_window(input int hits, input int kind, input bit gaps, input string rq);
      int lvl0;
      int n;
      lvl0 = exp_lvl;
      if (kind != 0) q.push_back('{kind == 1, lvl0});
      for (int i = 0; i < int'(WIN); i++) begin
         if (i == int'(WIN) - 1) chk(adj_req == 1'b0, "R1 early close", int'(adj_req), 0);
         if (gaps) lookup(1'b0, 1'b1);
         lookup(1'b1, i < hits);
      end
      lk_valid = 1'b0;
      if (kind == 0) begin
         chk(adj_req == 1'b0, rq, int'(adj_req), 0);
         chk(gran_level == LW'(lvl0), "R8 level unchanged", int'(gran_level), lvl0);
      end else begin
         chk(adj_req == 1'b1, rq, int'(adj_req), 1);
         n = 0;
         while (adj_req && n < 100) begin
            n++;
            lookup(1'b1, 1'b0);   // R6: misses during the pending request
         end
         lk_valid = 1'b0;
         chk(n == (kind == 1 ? 1 : 8), "R5 request held until ack", n, kind == 1 ? 1 : 8);
         exp_lvl = (kind == 1) ? lvl0 - 1 : lvl0 + 1;
         chk(gran_level == LW'(exp_lvl), "R8 level after ack", int'(gran_level), exp_lvl);
         for (int i = 0; i < int'(SETL); i++) lookup(1'b1, 1'b1);   // R7: ignored hits
         lk_valid = 1'b0;
      end
      lookup(1'b0, 1'b0);
   endtask

   initial begin
      rst = 1'b1; lk_valid = 1'b0; lk_hit = 1'b0;
      exp_lvl = LINIT;
      repeat (3) @(negedge clk);
      chk(adj_req == 1'b0, "R10 reset req", int'(adj_req), 0);
      chk(gran_level == LW'(LINIT), "R10 reset level", int'(gran_level), LINIT);
      rst = 1'b0;
      @(negedge clk);

      run_window(38, 1, 1'b0, "R2 split at 95%");           // 1 -> 0
      run_window(40, 0, 1'b0, "R9 split suppressed at min");
      run_window(37, 0, 1'b0, "R4 middle band");
      run_window(36, 2, 1'b0, "R3 merge at 90%");           // 0 -> 1
      run_window(0,  2, 1'b0, "R3 merge all misses");       // 1 -> 2
      run_window(10, 2, 1'b0, "R3 merge low ratio");        // 2 -> 3
      run_window(5,  0, 1'b0, "R9 merge suppressed at max");
      run_window(37, 0, 1'b1, "R1 R4 gaps not counted");
      run_window(39, 1, 1'b1, "R2 split with gaps");        // 3 -> 2

      // R10: reset in the middle of a partly filled window
      for (int i = 0; i < 20; i++) lookup(1'b1, 1'b0);
      rst = 1'b1;
      lookup(1'b0, 1'b0);
      lookup(1'b0, 1'b0);
      chk(gran_level == LW'(LINIT), "R10 mid-run reset level", int'(gran_level), LINIT);
      chk(adj_req == 1'b0, "R10 mid-run reset req", int'(adj_req), 0);
      rst = 1'b0;
      exp_lvl = LINIT;
      lookup(1'b0, 1'b0);
      run_window(38, 1, 1'b0, "R10 R2 fresh window after reset");   // 1 -> 0

      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R2/R3 missing request", q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule